// File: doc/BRIEF.md
# Bit-Addressable Internal Data Memory

This block holds a 128-byte on-chip data RAM and the address logic that lets a processor core reach it in three ways. It serves a whole byte by its 8-bit direct address, a working register by a 3-bit register number placed in one of four banks, and a single bit by an 8-bit bit address. Bit addresses below 80H land in a 16-byte window of the RAM that starts at 20H. Bit addresses from 80H upward land on special-function bytes whose addresses are multiples of eight. Those bytes live outside this block and are reached through a plain request port.

The core drives at most one request per cycle. If several requests arrive together, the bit request is served first, then the register request, then the byte request. A byte or register write takes effect at the clock edge that ends the request cycle. Read results appear one cycle after the request. Setting or clearing a single bit is a read-modify-write: the byte is fetched in the request cycle and written back in the following cycle. The block raises `busy` during that write-back cycle and ignores any request presented while it is high.

Top module: `iram_bitmem`

## Requirements
- R1: After a synchronous active-low reset every RAM byte reads 00H, and `busy`, `rd_valid` and `bit_valid` are low.
- R2: A byte write to an address below 80H stores the data. A byte read of such an address returns the stored byte on `rd_data` with `rd_valid` high in the cycle after the request.
- R3: A byte access to an address of 80H or above is not applied to the RAM. In the request cycle it appears on the SFR port with the same address, data and write flag. For a read, the `sfr_rdata` value sampled at the end of that cycle is returned on `rd_data` one cycle later.
- R4: A register access to register n goes to RAM byte bank×8+n. The bank is the value of `bank_sel`, so 00, 01, 10 and 11 select banks 0, 1, 2 and 3 (R5 of bank 3 is 1DH).
- R5: A bit address a below 80H selects bit (a & 7) of RAM byte 20H + (a >> 3). For example, 67H is bit 7 of 2CH and 2BH is bit 3 of 25H.
- R6: A bit address a of 80H or above selects bit (a & 7) of the SFR byte at (a & F8H). It is read through the SFR port in the request cycle and, for a write, written back through that port in the next cycle.
- R7: A bit write with `bit_wr`=1 stores `bit_val` in the selected bit and leaves the other seven bits of that byte unchanged.
- R8: A bit read (`bit_req`=1, `bit_wr`=0) returns the selected bit on `bit_rdata` with `bit_valid` high in the cycle after the request.
- R9: A bit write raises `busy` for exactly the one cycle after the request. Any request presented during that cycle has no effect.
- R10: When requests coincide, a bit request takes priority over a register request, which takes priority over a byte request. Only the winner is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_sel | input | 2 | Working-register bank from the status word |
| byte_req | input | 1 | Direct byte access request |
| byte_we | input | 1 | Byte access is a write |
| byte_addr | input | 8 | Direct byte address |
| byte_wdata | input | 8 | Byte write data |
| reg_req | input | 1 | Working-register access request |
| reg_we | input | 1 | Register access is a write |
| reg_num | input | 3 | Register number within the bank |
| reg_wdata | input | 8 | Register write data |
| bit_req | input | 1 | Single-bit access request |
| bit_wr | input | 1 | 1: write `bit_val`, 0: read the bit |
| bit_val | input | 1 | Value written to the bit |
| bit_addr | input | 8 | Bit address |
| rd_valid | output | 1 | `rd_data` holds a byte or register read result |
| rd_data | output | 8 | Read result |
| bit_valid | output | 1 | `bit_rdata` holds a bit read result |
| bit_rdata | output | 1 | Bit read result |
| busy | output | 1 | Bit write-back cycle; requests ignored |
| sfr_req | output | 1 | SFR port request |
| sfr_we | output | 1 | SFR port write |
| sfr_addr | output | 8 | SFR byte address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, returned combinationally for `sfr_addr` |

## Verification
The hardest situation to reach from the ports is a request that arrives in the write-back cycle of a bit write. For a byte that is not targeted, that request must leave no trace at all. The bench presents a bit write and, on the very next cycle, drives a byte write to an unrelated address. It then reads that address back and expects the old value. Most of the rest of the bench is sweeps: every RAM byte, every register in every bank, and all 256 bit addresses are flipped and read back. The SFR half uses a bench-side byte model, and expected bytes are computed from the address arithmetic.

// File: rtl/iram_pkg.sv
// Shared widths and the decoded bit-location record for the internal data memory.
package iram_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    // Where one addressed bit lives: target space, byte address, bit index.
    typedef struct packed {
        logic              to_sfr;
        addr_t             byte_addr;
        logic [IDX_W-1:0]  bit_idx;
    } bitloc_t;
endpackage

// File: rtl/iram_bitmap.sv
// Bit-address decoder.
// Purpose: turns an 8-bit bit address into a byte location and a bit index.
// Lower half: RAM window starting at BIT_BASE, eight bits per byte.
// Upper half: SFR byte at the address with its low three bits cleared.
// Assumes: eight bits per byte; purely combinational.
module iram_bitmap
    import iram_pkg::*;
#(
    parameter addr_t BIT_BASE = 8'h20
) (
    input  addr_t   bit_addr,
    output bitloc_t loc
);
    localparam int WIN_W = ADDR_W - 1 - IDX_W;

    // Split the bit address into target space, byte and index.
    always_comb begin
        loc.bit_idx = bit_addr[IDX_W-1:0];
        loc.to_sfr  = bit_addr[ADDR_W-1];
        if (bit_addr[ADDR_W-1]) begin
            loc.byte_addr = {bit_addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
        end else begin
            loc.byte_addr = BIT_BASE
                          + addr_t'({{(ADDR_W-WIN_W){1'b0}}, bit_addr[ADDR_W-2:IDX_W]});
        end
    end
endmodule

// File: rtl/iram_bankmap.sv
// Working-register address translation.
// Purpose: places register number rnum inside the bank chosen by bank.
// Assumes: banks are contiguous from address 0, REGS bytes each.
module iram_bankmap
    import iram_pkg::*;
#(
    parameter int REGS  = 8,
    parameter int REG_W = $clog2(REGS)
) (
    input  logic [1:0]       bank,
    input  logic [REG_W-1:0] rnum,
    output addr_t            addr
);
    // Bank base plus register offset.
    always_comb begin
        addr = addr_t'(bank) * addr_t'(REGS) + addr_t'(rnum);
    end
endmodule

// File: rtl/iram_array.sv
// Data RAM storage: one synchronous read port and one write port.
// Purpose: holds DEPTH bytes, all cleared by reset.
// The read result is held until the next read.
// Assumes: the caller never reads and writes the same address in one cycle.
module iram_array
    import iram_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_addr,
    output data_t         rd_q,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  data_t         wr_data
);
    data_t mem [DEPTH];

    // Clear on reset; otherwise perform the write and the registered read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
            rd_q <= '0;
        end else begin
            if (wr_en) begin
                mem[wr_addr] <= wr_data;
            end
            if (rd_en) begin
                rd_q <= mem[rd_addr];
            end
        end
    end
endmodule

// File: rtl/iram_bitmem.sv
// Bit-addressable internal data memory, top level.
// Purpose: arbitrates byte, register and bit requests (bit > register > byte).
// Maps each request onto the RAM or the SFR port.
// Runs a two-cycle read-modify-write for single-bit writes.
// Assumes: the SFR port answers reads combinationally in the request cycle;
// DEPTH bytes of RAM sit below the SFR space.
module iram_bitmem
    import iram_pkg::*;
#(
    parameter int    DEPTH         = 128,
    parameter addr_t BIT_BASE      = 8'h20,
    parameter int    REGS_PER_BANK = 8,
    parameter int    REG_W         = $clog2(REGS_PER_BANK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bank_sel,
    input  logic             byte_req,
    input  logic             byte_we,
    input  logic [7:0]       byte_addr,
    input  logic [7:0]       byte_wdata,
    input  logic             reg_req,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_num,
    input  logic [7:0]       reg_wdata,
    input  logic             bit_req,
    input  logic             bit_wr,
    input  logic             bit_val,
    input  logic [7:0]       bit_addr,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             bit_valid,
    output logic             bit_rdata,
    output logic             busy,
    output logic             sfr_req,
    output logic             sfr_we,
    output logic [7:0]       sfr_addr,
    output logic [7:0]       sfr_wdata,
    input  logic [7:0]       sfr_rdata
);
    localparam int    IW      = $clog2(DEPTH);
    localparam addr_t RAM_TOP = addr_t'(DEPTH - 1);

    bitloc_t bloc;
    addr_t   reg_addr;

    iram_bitmap #(.BIT_BASE(BIT_BASE)) u_bitmap (
        .bit_addr (bit_addr),
        .loc      (bloc)
    );

    iram_bankmap #(.REGS(REGS_PER_BANK), .REG_W(REG_W)) u_bankmap (
        .bank (bank_sel),
        .rnum (reg_num),
        .addr (reg_addr)
    );

    // Pipeline state between the request cycle and the result cycle.
    logic             busy_q;
    logic             byte_rd_q;
    logic             bit_rd_q;
    logic             src_sfr_q;
    data_t            sfr_cap;
    addr_t            rmw_addr;
    logic [IDX_W-1:0] idx_q;
    logic             val_q;

    // Arbitration: nothing new is accepted during a write-back cycle.
    logic go, sel_bit, sel_reg, sel_byte, acc_valid;
    assign go        = !busy_q;
    assign sel_bit   = go && bit_req;
    assign sel_reg   = go && !bit_req && reg_req;
    assign sel_byte  = go && !bit_req && !reg_req && byte_req;
    assign acc_valid = sel_bit || sel_reg || sel_byte;

    addr_t acc_addr;
    data_t acc_wd;
    logic  acc_sfr, acc_we;

    // Pick the address, target space and write data of the winning request.
    always_comb begin
        acc_addr = byte_addr;
        acc_wd   = byte_wdata;
        acc_sfr  = byte_addr > RAM_TOP;
        acc_we   = sel_byte && byte_we;
        if (sel_bit) begin
            acc_addr = bloc.byte_addr;
            acc_sfr  = bloc.to_sfr;
            acc_we   = 1'b0;
        end else if (sel_reg) begin
            acc_addr = reg_addr;
            acc_wd   = reg_wdata;
            acc_sfr  = 1'b0;
            acc_we   = reg_we;
        end
    end

    // Byte fetched in the request cycle, seen in the following cycle.
    data_t ram_q, fetched, merged;
    assign fetched = src_sfr_q ? sfr_cap : ram_q;

    // Replace only the addressed bit during write-back.
    for (genvar g = 0; g < DATA_W; g++) begin : g_merge
        assign merged[g] = (idx_q == IDX_W'(g)) ? val_q : fetched[g];
    end

    // RAM port control: the write-back cycle owns the write port.
    logic          ram_rd_en, ram_wr_en;
    logic [IW-1:0] ram_wr_addr;
    data_t         ram_wr_data;
    always_comb begin
        ram_rd_en   = acc_valid && !acc_sfr && !acc_we;
        ram_wr_en   = acc_valid && !acc_sfr && acc_we;
        ram_wr_addr = acc_addr[IW-1:0];
        ram_wr_data = acc_wd;
        if (busy_q) begin
            ram_wr_en   = !src_sfr_q;
            ram_wr_addr = rmw_addr[IW-1:0];
            ram_wr_data = merged;
        end
    end

    iram_array #(.DEPTH(DEPTH), .IW(IW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (ram_rd_en),
        .rd_addr (acc_addr[IW-1:0]),
        .rd_q    (ram_q),
        .wr_en   (ram_wr_en),
        .wr_addr (ram_wr_addr),
        .wr_data (ram_wr_data)
    );

    // SFR port control: request-cycle access or write-back of the merged byte.
    always_comb begin
        sfr_req   = acc_valid && acc_sfr;
        sfr_we    = acc_we;
        sfr_addr  = acc_addr;
        sfr_wdata = acc_wd;
        if (busy_q) begin
            sfr_req   = src_sfr_q;
            sfr_we    = 1'b1;
            sfr_addr  = rmw_addr;
            sfr_wdata = merged;
        end
    end

    // Record what the next cycle must return or write back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            byte_rd_q <= 1'b0;
            bit_rd_q  <= 1'b0;
            src_sfr_q <= 1'b0;
            sfr_cap   <= '0;
            rmw_addr  <= '0;
            idx_q     <= '0;
            val_q     <= 1'b0;
        end else begin
            busy_q    <= sel_bit && bit_wr;
            byte_rd_q <= (sel_reg || sel_byte) && !acc_we;
            bit_rd_q  <= sel_bit && !bit_wr;
            if (acc_valid) begin
                src_sfr_q <= acc_sfr;
            end
            if (acc_valid && acc_sfr && !acc_we) begin
                sfr_cap <= sfr_rdata;
            end
            if (sel_bit) begin
                rmw_addr <= bloc.byte_addr;
                idx_q    <= bloc.bit_idx;
                val_q    <= bit_val;
            end
        end
    end

    assign busy      = busy_q;
    assign rd_valid  = byte_rd_q;
    assign rd_data   = fetched;
    assign bit_valid = bit_rd_q;
    assign bit_rdata = fetched[idx_q];
endmodule

// File: rtl/iram_bitmem_chk.sv
// Protocol checker for iram_bitmem (default 128-byte RAM, SFR space from 80H).
// Attached to every instance through the bind at the end of this file.
module iram_bitmem_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_req,
    input logic [7:0] byte_addr,
    input logic       reg_req,
    input logic       bit_req,
    input logic       bit_wr,
    input logic [7:0] bit_addr,
    input logic       busy,
    input logic       rd_valid,
    input logic       bit_valid,
    input logic       sfr_req,
    input logic       sfr_we,
    input logic [7:0] sfr_addr
);
    a_r9_busy_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    a_r9_bit_write_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_req && bit_wr && !busy) |=> busy);

    a_r9_no_result_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!rd_valid && !bit_valid));

    a_r9_writeback_is_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sfr_req) |-> sfr_we);

    a_r8_bit_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_req && !bit_wr && !busy) |=> (bit_valid && !rd_valid));

    a_r3_high_byte_to_sfr: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && !bit_req && !reg_req && !busy && byte_addr[7])
        |-> (sfr_req && sfr_addr == byte_addr));

    a_r5_low_bit_stays_in_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_req && !bit_addr[7] && !busy) |-> !sfr_req);

    a_r6_high_bit_reads_sfr: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_req && bit_addr[7] && !busy)
        |-> (sfr_req && !sfr_we && sfr_addr == {bit_addr[7:3], 3'b000}));

    a_r4_register_stays_in_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !bit_req && !busy) |-> !sfr_req);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!busy && !rd_valid && !bit_valid));
endmodule

bind iram_bitmem iram_bitmem_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_req  (byte_req),
    .byte_addr (byte_addr),
    .reg_req   (reg_req),
    .bit_req   (bit_req),
    .bit_wr    (bit_wr),
    .bit_addr  (bit_addr),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .bit_valid (bit_valid),
    .sfr_req   (sfr_req),
    .sfr_we    (sfr_we),
    .sfr_addr  (sfr_addr)
);

// File: tb/tb_iram_bitmem.sv
// Sweeping bench for iram_bitmem with a bench-side SFR byte model.
module tb_iram_bitmem;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bank_sel = '0;
    logic       byte_req = 0, byte_we = 0;
    logic [7:0] byte_addr = '0, byte_wdata = '0;
    logic       reg_req = 0, reg_we = 0;
    logic [2:0] reg_num = '0;
    logic [7:0] reg_wdata = '0;
    logic       bit_req = 0, bit_wr = 0, bit_val = 0;
    logic [7:0] bit_addr = '0;
    logic       rd_valid, bit_valid, bit_rdata, busy;
    logic [7:0] rd_data;
    logic       sfr_req, sfr_we;
    logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0] ram_exp [128];
    logic [7:0] sfr_mem [128];
    logic [7:0] sfr_exp [128];

    always #2.5 clk = ~clk;

    iram_bitmem dut (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .byte_req(byte_req), .byte_we(byte_we), .byte_addr(byte_addr), .byte_wdata(byte_wdata),
        .reg_req(reg_req), .reg_we(reg_we), .reg_num(reg_num), .reg_wdata(reg_wdata),
        .bit_req(bit_req), .bit_wr(bit_wr), .bit_val(bit_val), .bit_addr(bit_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .bit_valid(bit_valid), .bit_rdata(bit_rdata),
        .busy(busy), .sfr_req(sfr_req), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    // External special-function bytes: combinational read, clocked write.
    assign sfr_rdata = sfr_mem[sfr_addr[6:0]];
    always @(posedge clk) begin
        if (sfr_req && sfr_we) sfr_mem[sfr_addr[6:0]] <= sfr_wdata;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr();
        byte_req = 0; byte_we = 0; reg_req = 0; reg_we = 0; bit_req = 0; bit_wr = 0;
    endtask

    task automatic byte_write(input logic [7:0] a, input logic [7:0] d);
        byte_req = 1; byte_we = 1; byte_addr = a; byte_wdata = d;
        @(negedge clk); clr();
        if (a < 8'h80) ram_exp[a[6:0]] = d; else sfr_exp[a[6:0]] = d;
    endtask

    task automatic byte_read(input logic [7:0] a, input string req);
        byte_req = 1; byte_we = 0; byte_addr = a;
        @(negedge clk); clr();
        if (a < 8'h80)
            check(rd_valid && rd_data == ram_exp[a[6:0]], req, {rd_valid, rd_data}, {1'b1, ram_exp[a[6:0]]});
        else
            check(rd_valid && rd_data == sfr_exp[a[6:0]], req, {rd_valid, rd_data}, {1'b1, sfr_exp[a[6:0]]});
    endtask

    function automatic logic [7:0] bit_byte(input logic [7:0] a);
        return (a < 8'h80) ? 8'(32 + a / 8) : (a & 8'hF8);
    endfunction

    function automatic logic exp_bit(input logic [7:0] a);
        logic [7:0] b = bit_byte(a);
        return (a < 8'h80) ? ram_exp[b[6:0]][a % 8] : sfr_exp[b[6:0]][a % 8];
    endfunction

    task automatic bit_read(input logic [7:0] a, input string req);
        logic e;
        e = exp_bit(a);
        bit_req = 1; bit_wr = 0; bit_addr = a;
        @(negedge clk); clr();
        check(bit_valid && bit_rdata == e, req, {bit_valid, bit_rdata}, {1'b1, e});
    endtask

    task automatic bit_write(input logic [7:0] a, input logic v);
        logic [7:0] b;
        b = bit_byte(a);
        bit_req = 1; bit_wr = 1; bit_addr = a; bit_val = v;
        @(negedge clk); clr();
        check(busy == 1'b1, "R9 busy in write-back", busy, 1);
        @(negedge clk);
        check(busy == 1'b0, "R9 busy one cycle", busy, 0);
        if (a < 8'h80) ram_exp[b[6:0]][a % 8] = v; else sfr_exp[b[6:0]][a % 8] = v;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) begin
            ram_exp[i] = 8'h00;
            sfr_mem[i] = 8'(i * 13 + 7);
            sfr_exp[i] = 8'(i * 13 + 7);
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        check(!busy && !rd_valid && !bit_valid, "R1 outputs idle", {busy, rd_valid, bit_valid}, 0);
        for (int a = 0; a < 128; a++) byte_read(8'(a), "R1 RAM cleared");

        // R2: full byte sweep with an address-derived pattern
        for (int a = 0; a < 128; a++) byte_write(8'(a), 8'(a * 37 + 11));
        for (int a = 0; a < 128; a++) byte_read(8'(a), "R2 byte readback");

        // R3: SFR byte reads and writes through the port
        for (int a = 128; a < 256; a += 5) byte_read(8'(a), "R3 SFR byte read");
        byte_write(8'h9A, 8'h3C);
        check(sfr_mem[7'h1A] == 8'h3C, "R3 SFR byte write", sfr_mem[7'h1A], 8'h3C);
        byte_read(8'h9A, "R3 SFR readback");
        check(ram_exp[7'h1A] == 8'(26 * 37 + 11), "R3 RAM untouched", ram_exp[7'h1A], 8'(26 * 37 + 11));
        byte_read(8'h1A, "R3 RAM untouched by SFR write");

        // R4: every register in every bank lands at bank*8+n
        for (int b = 0; b < 4; b++) begin
            bank_sel = 2'(b);
            for (int n = 0; n < 8; n++) begin
                reg_req = 1; reg_we = 1; reg_num = 3'(n); reg_wdata = 8'(b * 64 + n * 5 + 1);
                @(negedge clk); clr();
                ram_exp[b * 8 + n] = 8'(b * 64 + n * 5 + 1);
            end
        end
        for (int a = 0; a < 32; a++) byte_read(8'(a), "R4 register placement");
        bank_sel = 2'd3; reg_req = 1; reg_we = 0; reg_num = 3'd5;
        @(negedge clk); clr();
        check(rd_valid && rd_data == ram_exp[8'h1D], "R4 R5 of bank 3 is 1DH", rd_data, ram_exp[8'h1D]);

        // R5, R7, R8: all RAM bit addresses, read then flipped and verified
        for (int a = 0; a < 128; a++) begin
            logic v;
            bit_read(8'(a), "R8 RAM bit read");
            v = !exp_bit(8'(a));
            bit_write(8'(a), v);
            byte_read(bit_byte(8'(a)), "R5 R7 RAM bit write");
        end
        check(bit_byte(8'h67) == 8'h2C, "R5 67H in 2CH", bit_byte(8'h67), 8'h2C);

        // R6, R7: all SFR bit addresses
        for (int a = 128; a < 256; a++) begin
            logic v;
            bit_read(8'(a), "R6 SFR bit read");
            v = !exp_bit(8'(a));
            bit_write(8'(a), v);
            byte_read(bit_byte(8'(a)), "R6 R7 SFR bit write");
        end

        // R9: byte write presented during write-back is ignored
        bit_req = 1; bit_wr = 1; bit_addr = 8'h00; bit_val = 1'b1;
        @(negedge clk); clr();
        byte_req = 1; byte_we = 1; byte_addr = 8'h41; byte_wdata = 8'h99;
        @(negedge clk); clr();
        ram_exp[8'h20][0] = 1'b1;
        byte_read(8'h41, "R9 ignored while busy");
        byte_read(8'h20, "R9 bit write completed");

        // R10: register beats byte, bit beats byte
        bank_sel = 2'd1;
        reg_req = 1; reg_we = 1; reg_num = 3'd2; reg_wdata = 8'h5A;
        byte_req = 1; byte_we = 1; byte_addr = 8'h60; byte_wdata = 8'hC3;
        @(negedge clk); clr();
        ram_exp[8'h0A] = 8'h5A;
        byte_read(8'h0A, "R10 register wins");
        byte_read(8'h60, "R10 byte lost");
        bit_req = 1; bit_wr = 0; bit_addr = 8'h05; byte_req = 1; byte_we = 0; byte_addr = 8'h40;
        @(negedge clk); clr();
        check(bit_valid && !rd_valid, "R10 bit wins over byte", {bit_valid, rd_valid}, 2'b10);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule